// File: doc/BRIEF.md
# NAND Access Phase Timing Sequencer

This block times a single access to the common memory space of a NAND flash device. The access begins with a one-cycle start request and a read/write flag. The block then steps through four phases: address setup, command strobe, wait extension and hold. It drives an active-low write strobe or an active-low read strobe, an address-valid enable, a data output enable and a one-cycle completion pulse. Every duration is a count of kernel clock cycles, taken from four 8-bit timing fields.

The command strobe lasts a programmable minimum time. If the device holds its active-low wait line low when that minimum runs out, the strobe stays asserted until the line is released. The wait line passes through a two-flop synchronizer before the sequencer uses it. A read holds the address two cycles longer than a write does. On a write, the data bus is kept high-impedance for a programmable number of cycles from the start of the access, and this time may overlap the setup phase. Reserved field codes are clamped to the nearest legal value. The timing fields and the read/write flag are captured when a start is accepted.

Top module: `nand_phase_seq`

## Requirements
- R1: While reset is low, both strobes are high and the address enable, data enable and done outputs are low.
- R2: After an accepted start, the address enable is high with both strobes inactive for exactly setup+1 cycles before the strobe asserts.
- R3: With the wait input held high, the strobe stays low for wait+1 cycles, and a wait field of 0 gives 2 cycles.
- R4: If the wait input is low when the programmed strobe time ends, the strobe stays low until the wait input rises. It deasserts on the third rising clock edge after that rise, which accounts for the two-flop synchronizer.
- R5: On a write, the address enable stays high for exactly hold cycles after the strobe deasserts.
- R6: On a read, the address enable stays high for exactly hold+2 cycles after the strobe deasserts.
- R7: A hold field of 0 acts as 1, and a hold field of 255 acts as 254.
- R8: On a write, the data enable is low for the first hiz cycles of the access and high for the rest of it. A Hi-Z field of 255 acts as 254. The data enable is never high during a read.
- R9: The write strobe asserts only on writes and the read strobe only on reads, and the two are never low together.
- R10: Done is high for exactly one cycle, in the first cycle after the hold phase, when the address enable is already low.
- R11: A start that arrives during an access is ignored. It does not change the current access and does not begin a new one.
- R12: The address enable stays high from the first setup cycle through the last hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Access request, accepted only when idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| setup_i | input | 8 | Address setup field |
| wait_i | input | 8 | Minimum command strobe field |
| hold_i | input | 8 | Address/data hold field |
| hiz_i | input | 8 | Write data Hi-Z field |
| nwait_i | input | 1 | Active-low device wait input (asynchronous) |
| we_n_o | output | 1 | Active-low write strobe |
| re_n_o | output | 1 | Active-low read strobe |
| addr_en_o | output | 1 | Address valid enable |
| data_oe_o | output | 1 | Write data output enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the wait extension. The wait line must already be low, after the synchronizer, when the programmed strobe count expires, and the bench must then know the exact cycle at which the strobe is released. The bench pulls the wait input low before issuing the start. It raises the input at a chosen negative clock edge well after the command phase would have ended. It then expects the strobe to stay low for two more sampled cycles. The ignored-start case is reached by pulsing start with the opposite direction flag in the middle of an access. The bench then checks that the phase lengths are unchanged and that no second access follows the done pulse.

// File: rtl/nand_tim_pkg.sv
// Shared types for the NAND access phase sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package nand_tim_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_CMD   = 3'd2,
        PH_WAITX = 3'd3,
        PH_HOLD  = 3'd4
    } phase_t;
endpackage

// File: rtl/nand_wait_sync.sv
// Two-flop synchronizer for the asynchronous active-low device wait line.
// Assumes: the extra two cycles of latency are acceptable; resets to "not waiting".
module nand_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic sync_q;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/nand_field_clamp.sv
// Maps raw timing fields to phase counter reload values (length minus one).
// Reserved codes are clamped: hold 0 -> 1, hold max -> max-1, Hi-Z max -> max-1,
// and wait 0 -> 1. Read hold is extended by two cycles.
// Assumes: CNT_W is FIELD_W+1 so that hold+1 never overflows.
module nand_field_clamp #(
    parameter int FIELD_W = 8,
    parameter int CNT_W   = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] setup_i,
    input  logic [FIELD_W-1:0] wait_i,
    input  logic [FIELD_W-1:0] hold_i,
    input  logic [FIELD_W-1:0] hiz_i,
    input  logic               write_i,
    output logic [CNT_W-1:0]   setup_m1_o,
    output logic [CNT_W-1:0]   cmd_m1_o,
    output logic [CNT_W-1:0]   hold_m1_o,
    output logic [FIELD_W-1:0] hiz_o
);
    localparam logic [FIELD_W-1:0] FMAX = '1;
    localparam logic [FIELD_W-1:0] FONE = FIELD_W'(1);
    localparam int                 PAD  = CNT_W - FIELD_W;

    logic [FIELD_W-1:0] hold_c;

    // Clamp each field and form the reload values.
    always_comb begin
        if (hold_i == '0)
            hold_c = FONE;
        else if (hold_i == FMAX)
            hold_c = FMAX - FONE;
        else
            hold_c = hold_i;

        setup_m1_o = {{PAD{1'b0}}, setup_i};
        cmd_m1_o   = {{PAD{1'b0}}, ((wait_i == '0) ? FONE : wait_i)};
        if (write_i)
            hold_m1_o = {{PAD{1'b0}}, hold_c} - CNT_W'(1);
        else
            hold_m1_o = {{PAD{1'b0}}, hold_c} + CNT_W'(1);
        hiz_o = (hiz_i == FMAX) ? (FMAX - FONE) : hiz_i;
    end
endmodule

// File: rtl/nand_phase_counter.sv
// Down counter shared by all timed phases. A load starts a phase of
// (val+1) cycles, and zero_o marks the last cycle of that phase.
// Assumes: the counter holds at zero between phases.
module nand_phase_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Reload on a phase change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nand_hiz_timer.sv
// Counts the write data Hi-Z window from the start of an access.
// next_zero_o gives the state after the coming edge, so that a registered
// enable can follow it without losing a cycle.
// Assumes: it is loaded on the same edge that accepts a start.
module nand_hiz_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         next_zero_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // Next value: load, or decrement until zero.
    always_comb begin
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
        else
            cnt_d = cnt_q;
    end

    // Hold the window count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign next_zero_o = (cnt_d == '0);
endmodule

// File: rtl/nand_phase_seq.sv
// Timing sequencer for one NAND common-memory access. The phases are
// setup (setup+1 cycles), command (max(wait,1)+1 cycles, extended while the
// synchronized wait is low) and hold (hold cycles on a write, hold+2 on a read).
// All outputs are registered from the next phase, so the strobes cannot glitch.
// Assumes: the fields are stable in the start cycle; a start is taken only when idle.
module nand_phase_seq #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               write_i,
    input  logic [FIELD_W-1:0] setup_i,
    input  logic [FIELD_W-1:0] wait_i,
    input  logic [FIELD_W-1:0] hold_i,
    input  logic [FIELD_W-1:0] hiz_i,
    input  logic               nwait_i,
    output logic               we_n_o,
    output logic               re_n_o,
    output logic               addr_en_o,
    output logic               data_oe_o,
    output logic               done_o
);
    import nand_tim_pkg::*;

    localparam int CNT_W = FIELD_W + 1;

    phase_t             ph_q, ph_d;
    logic               accept;
    logic               wait_s;
    logic               ld;
    logic [CNT_W-1:0]   ld_val;
    logic               cnt_zero;
    logic               hz_next_zero;
    logic               wr_q, wr_d;
    logic               cmd_d;
    logic [CNT_W-1:0]   setup_m1_c, cmd_m1_c, hold_m1_c;
    logic [FIELD_W-1:0] hiz_c;
    logic [CNT_W-1:0]   cmd_m1_q, hold_m1_q;
    logic               we_n_q, re_n_q, addr_en_q, data_oe_q, done_q;

    assign accept = start_i && (ph_q == PH_IDLE);

    nand_wait_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (nwait_i),
        .sync_o  (wait_s)
    );

    nand_field_clamp #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_clamp (
        .setup_i    (setup_i),
        .wait_i     (wait_i),
        .hold_i     (hold_i),
        .hiz_i      (hiz_i),
        .write_i    (write_i),
        .setup_m1_o (setup_m1_c),
        .cmd_m1_o   (cmd_m1_c),
        .hold_m1_o  (hold_m1_c),
        .hiz_o      (hiz_c)
    );

    nand_phase_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .zero_o (cnt_zero)
    );

    nand_hiz_timer #(.W(FIELD_W)) u_hiz (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .val_i       (hiz_c),
        .next_zero_o (hz_next_zero)
    );

    // Capture the direction and the clamped later-phase lengths at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            cmd_m1_q  <= '0;
            hold_m1_q <= '0;
        end else if (accept) begin
            wr_q      <= write_i;
            cmd_m1_q  <= cmd_m1_c;
            hold_m1_q <= hold_m1_c;
        end
    end

    // Next phase and counter reload.
    always_comb begin
        ph_d   = ph_q;
        ld     = 1'b0;
        ld_val = setup_m1_c;
        case (ph_q)
            PH_IDLE: begin
                if (start_i) begin
                    ph_d   = PH_SETUP;
                    ld     = 1'b1;
                    ld_val = setup_m1_c;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    ph_d   = PH_CMD;
                    ld     = 1'b1;
                    ld_val = cmd_m1_q;
                end
            end
            PH_CMD: begin
                if (cnt_zero) begin
                    if (!wait_s) begin
                        ph_d = PH_WAITX;
                    end else begin
                        ph_d   = PH_HOLD;
                        ld     = 1'b1;
                        ld_val = hold_m1_q;
                    end
                end
            end
            PH_WAITX: begin
                if (wait_s) begin
                    ph_d   = PH_HOLD;
                    ld     = 1'b1;
                    ld_val = hold_m1_q;
                end
            end
            PH_HOLD: begin
                if (cnt_zero)
                    ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    assign wr_d  = accept ? write_i : wr_q;
    assign cmd_d = (ph_d == PH_CMD) || (ph_d == PH_WAITX);

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_IDLE;
        else
            ph_q <= ph_d;
    end

    // Register every output from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n_q    <= 1'b1;
            re_n_q    <= 1'b1;
            addr_en_q <= 1'b0;
            data_oe_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            we_n_q    <= !(cmd_d && wr_d);
            re_n_q    <= !(cmd_d && !wr_d);
            addr_en_q <= (ph_d != PH_IDLE);
            data_oe_q <= (ph_d != PH_IDLE) && wr_d && hz_next_zero;
            done_q    <= (ph_q == PH_HOLD) && cnt_zero;
        end
    end

    assign we_n_o    = we_n_q;
    assign re_n_o    = re_n_q;
    assign addr_en_o = addr_en_q;
    assign data_oe_o = data_oe_q;
    assign done_o    = done_q;
endmodule

// File: rtl/nand_phase_seq_chk.sv
// Protocol checker for nand_phase_seq, attached by bind.
// Assumes: the port-level relations listed in the requirements.
module nand_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic we_n_o,
    input logic re_n_o,
    input logic addr_en_o,
    input logic data_oe_o,
    input logic done_o
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (we_n_o && re_n_o && !addr_en_o && !data_oe_o && !done_o));

    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n_o) || $fell(re_n_o)) |-> $past(addr_en_o));

    p_no_read_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n_o |-> !data_oe_o);

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !re_n_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!addr_en_o && $past(addr_en_o)));

    p_strobe_in_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o || !re_n_o || data_oe_o) |-> addr_en_o);
endmodule

bind nand_phase_seq nand_phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_n_o    (we_n_o),
    .re_n_o    (re_n_o),
    .addr_en_o (addr_en_o),
    .data_oe_o (data_oe_o),
    .done_o    (done_o)
);

// File: tb/nand_phase_seq_tb.sv
// Directed bench for nand_phase_seq: one task per scenario, outputs sampled on the falling edge.
module nand_phase_seq_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic [7:0] setup_i = '0;
    logic [7:0] wait_i = '0;
    logic [7:0] hold_i = '0;
    logic [7:0] hiz_i = '0;
    logic       nwait_i = 1'b1;
    logic       we_n_o, re_n_o, addr_en_o, data_oe_o, done_o;

    int checks = 0;
    int errors = 0;

    // results of the last access
    int m_setup, m_cmd, m_hold, m_hizlow, m_oehigh, m_done, m_wrong;
    int m_low_to_raise, m_done_addr, m_after, m_oe_gap;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .setup_i(setup_i), .wait_i(wait_i), .hold_i(hold_i), .hiz_i(hiz_i),
        .nwait_i(nwait_i), .we_n_o(we_n_o), .re_n_o(re_n_o),
        .addr_en_o(addr_en_o), .data_oe_o(data_oe_o), .done_o(done_o)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one access. inject: pulse an opposite-direction start mid access.
    // raise_at > 0: raise nwait at that sample index.
    task automatic run_access(input logic wr, input int s, input int w, input int h,
                              input int z, input bit inject, input int raise_at);
        bit seen_strobe = 0;
        bit seen_oe = 0;
        m_setup = 0; m_cmd = 0; m_hold = 0; m_hizlow = 0; m_oehigh = 0;
        m_done = 0; m_wrong = 0; m_low_to_raise = 0; m_done_addr = 0;
        m_after = 0; m_oe_gap = 0;
        @(negedge clk);
        start_i = 1'b1; write_i = wr;
        setup_i = 8'(s); wait_i = 8'(w); hold_i = 8'(h); hiz_i = 8'(z);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic strobe_low;
            strobe_low = wr ? !we_n_o : !re_n_o;
            if (wr ? !re_n_o : !we_n_o) m_wrong++;
            if (done_o) begin
                m_done++;
                m_done_addr = addr_en_o;
                break;
            end
            if (addr_en_o && !strobe_low && !seen_strobe) m_setup++;
            if (strobe_low) begin
                m_cmd++;
                seen_strobe = 1;
                if (raise_at > 0 && i <= raise_at) m_low_to_raise++;
            end
            if (addr_en_o && !strobe_low && seen_strobe) m_hold++;
            if (addr_en_o && !data_oe_o && wr) begin
                m_hizlow++;
                if (seen_oe) m_oe_gap++;
            end
            if (data_oe_o) begin
                m_oehigh++;
                seen_oe = 1;
            end
            if (raise_at > 0 && i == raise_at) nwait_i = 1'b1;
            if (inject && i == 3) begin
                start_i = 1'b1; write_i = !wr;
                setup_i = 8'd9; wait_i = 8'd9; hold_i = 8'd9; hiz_i = 8'd0;
            end
            if (inject && i == 4) start_i = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        m_after = int'(addr_en_o) + int'(done_o) + int'(!we_n_o) + int'(!re_n_o);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check_eq("R1", "we_n in reset", int'(we_n_o), 1);
        check_eq("R1", "re_n in reset", int'(re_n_o), 1);
        check_eq("R1", "addr_en in reset", int'(addr_en_o), 0);
        check_eq("R1", "data_oe in reset", int'(data_oe_o), 0);
        check_eq("R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_write_basic();
        run_access(1'b1, 2, 3, 2, 1, 1'b0, 0);
        check_eq("R2", "write setup", m_setup, 3);
        check_eq("R3", "write strobe", m_cmd, 4);
        check_eq("R5", "write hold", m_hold, 2);
        check_eq("R8", "write hiz cycles", m_hizlow, 1);
        check_eq("R8", "data enable gap", m_oe_gap, 0);
        check_eq("R9", "read strobe on write", m_wrong, 0);
        check_eq("R10", "done count", m_done, 1);
        check_eq("R10", "addr_en with done", m_done_addr, 0);
        check_eq("R12", "activity after done", m_after, 0);
    endtask

    task automatic t_read_basic();
        run_access(1'b0, 0, 1, 1, 5, 1'b0, 0);
        check_eq("R2", "read setup", m_setup, 1);
        check_eq("R3", "read strobe", m_cmd, 2);
        check_eq("R6", "read hold", m_hold, 3);
        check_eq("R8", "data enable on read", m_oehigh, 0);
        check_eq("R9", "write strobe on read", m_wrong, 0);
        check_eq("R10", "read done count", m_done, 1);
    endtask

    task automatic t_wait_zero();
        run_access(1'b1, 1, 0, 4, 0, 1'b0, 0);
        check_eq("R3", "wait 0 strobe", m_cmd, 2);
        check_eq("R8", "hiz 0 drives at once", m_hizlow, 0);
        check_eq("R12", "wait 0 total enable", m_oehigh, 2 + 2 + 4);
    endtask

    task automatic t_reserved();
        run_access(1'b1, 0, 1, 0, 0, 1'b0, 0);
        check_eq("R7", "write hold 0", m_hold, 1);
        run_access(1'b0, 0, 1, 255, 0, 1'b0, 0);
        check_eq("R7", "read hold 255", m_hold, 256);
        run_access(1'b1, 254, 5, 3, 255, 1'b0, 0);
        check_eq("R2", "setup 254", m_setup, 255);
        check_eq("R8", "hiz 255", m_hizlow, 254);
    endtask

    task automatic t_wait_ext();
        nwait_i = 1'b0;
        run_access(1'b1, 1, 2, 2, 0, 1'b0, 12);
        check_eq("R4", "extended strobe", m_cmd, m_low_to_raise + 2);
        check_eq("R4", "extended beyond minimum", int'(m_cmd > 3), 1);
        check_eq("R4", "setup unchanged", m_setup, 2);
        check_eq("R4", "hold after extension", m_hold, 2);
        nwait_i = 1'b1;
    endtask

    task automatic t_busy_start();
        run_access(1'b0, 2, 2, 2, 0, 1'b1, 0);
        check_eq("R11", "setup with stray start", m_setup, 3);
        check_eq("R11", "strobe with stray start", m_cmd, 3);
        check_eq("R11", "hold with stray start", m_hold, 4);
        check_eq("R11", "direction kept", m_wrong, 0);
        check_eq("R11", "no second access", m_after, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write_basic();
        t_read_basic();
        t_wait_zero();
        t_reserved();
        t_wait_ext();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule